// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial-bus slave that holds six 8-bit configuration registers for a clock-generation device. The host fills them with a block write: after the device address it sends a command byte and a length byte, which the slave acknowledges and throws away, and then data bytes that land in register 0, 1, 2 and upward in strict ascending order. There is no offset phase and no random addressing. The transfer may end after any whole byte.

A block read returns a length byte first and then streams the registers from index 0 upward. The four frequency-select strap pins are captured once, on the first clock after reset, and appear in the top nibble of the last register on readback. The register contents are presented continuously on a parallel output bus.

The bus pins are oversampled by the system clock through a two-flop synchroniser. SDA is open drain: the block pulls the line low by raising `sda_oe` and otherwise leaves it released. The slave never stretches the clock. The bus is a plain control path, so it has no valid/ready flow control. The host paces each byte, and the slave keeps up as long as the sampling rule in the Verification section holds.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x69. The address byte is sent MSB first with the R/W bit last, so 0xD2 is a write and 0xD3 is a read. Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. Each following data byte is stored in the next register, starting at index 0 and counting upward.
- R3: A stop after any complete byte ends the write. Registers already written keep their new values, and registers not reached keep their old values.
- R4: The slave acknowledges every byte it receives in a write by pulling SDA low (`sda_oe` = 1) through the ninth SCL pulse. Data bytes beyond register 5 are acknowledged and change no register.
- R5: A read returns the byte count 6, then registers 0 through 5, each MSB first. While the host keeps acknowledging past register 5, every further byte is 0xFF.
- R6: When the host does not acknowledge a read byte, the slave releases SDA and goes idle. It drives nothing until it is addressed again.
- R7: After reset `cfg_q` holds 0x0F_FF_FF_FF_FF_00, with register 0 in bits [7:0] equal to 0x00, and `sda_oe` is 0.
- R8: Bits [7:4] of register 5 are read-only. A read returns there the `strap_in` value captured on the first clock after reset, and later strap changes do not affect it. Writes to those bits are dropped, so they stay 0 in `cfg_q[47:44]`.
- R9: A stop in the middle of a byte abandons that byte and changes no register. A start in the middle of a byte also abandons the byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_in | input | 4 | Frequency-select strap pins, captured after reset |
| cfg_q | output | 48 | Register contents, register i in bits [8i+7:8i] |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except to make a start or a stop. It never issues a start or a stop while the slave is pulling SDA low. Each SCL high and low phase lasts well over three system clocks, so that the synchroniser and the edge detector see every transition in order. The bench drives the bus with a quarter-bit of 20 clocks. It changes data only in the low phase, and it places the mid-byte start and stop only in bit slots where the host owns the line.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_e;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s && !scl_prev;
  assign scl_fall  = !scl_s && scl_prev;
  assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
  assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile #(
  parameter int NREG = 6,
  parameter int STRAP_W = 4,
  parameter logic [8*NREG-1:0] RST_IMAGE = 48'h0F_FF_FF_FF_FF_00,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [CW-1:0]      rd_sel,
  output logic [7:0]         rd_byte,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [8*NREG-1:0]  cfg_q
);
  logic [STRAP_W-1:0] strap_q;
  logic strap_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q     <= '0;
      strap_taken <= 1'b0;
    end else if (!strap_taken) begin
      strap_q     <= strap_in;
      strap_taken <= 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] KEEP = (i == NREG - 1) ? 8'((1 << (8 - STRAP_W)) - 1) : 8'hFF;
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_IMAGE[8*i +: 8] & KEEP;
      else if (wr_en && wr_idx == IW'(i)) r <= wr_data & KEEP;
    end
    assign cfg_q[8*i +: 8] = r;
  end

  always_comb begin
    rd_byte = 8'hFF;
    if (rd_sel == '0) begin
      rd_byte = 8'(NREG);
    end else if (rd_sel <= CW'(NREG)) begin
      rd_byte = cfg_q[8*(int'(rd_sel) - 1) +: 8];
      if (rd_sel == CW'(NREG)) rd_byte[7 -: STRAP_W] = strap_q;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));
  // R8
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_taken |=> $stable(strap_q));
endmodule

// File: rtl/cfgs_engine.sv
module cfgs_engine
  import cfgs_pkg::*;
#(
  parameter int NREG = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [CW-1:0] rd_sel,
  input  logic [7:0]    rd_byte
);
  bus_state_e state;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sr, tx_sr;
  logic          rd_mode, host_ack;
  logic [CW-1:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      wr_cnt   <= '0;
      rd_sel   <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        wr_cnt  <= '0;
        rd_sel  <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              rx_sr   <= {rx_sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sr[7:1] == DEV_ADDR) begin
                  rd_mode <= rx_sr[0];
                  state   <= ST_ADDR_ACK;
                  sda_oe  <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state  <= ST_RX_ACK;
                sda_oe <= 1'b1;
                if (wr_cnt >= CW'(2) && (wr_cnt - CW'(2)) < CW'(NREG)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IW'(wr_cnt - CW'(2));
                  wr_data <= rx_sr;
                end
                if (wr_cnt != '1) wr_cnt <= wr_cnt + CW'(1);
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                tx_sr   <= rd_byte;
                sda_oe  <= ~rd_byte[7];
                bit_cnt <= '0;
                if (rd_sel != '1) rd_sel <= rd_sel + CW'(1);
                state   <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                host_ack <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                tx_sr   <= {tx_sr[6:0], 1'b0};
                sda_oe  <= ~tx_sr[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= !sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx_sr   <= rd_byte;
                sda_oe  <= ~rd_byte[7];
                bit_cnt <= '0;
                if (rd_sel != '1) rd_sel <= rd_sel + CW'(1);
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
  // R2
  wr_only_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == ST_RX_ACK));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int NREG = 6,
  parameter int STRAP_W = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [8*NREG-1:0] RST_IMAGE = 48'h0F_FF_FF_FF_FF_00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [8*NREG-1:0]  cfg_q
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 3);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0] wr_data, rd_byte;
  logic [CW-1:0] rd_sel;

  cfgs_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgs_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_s(scl_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_byte(rd_byte)
  );

  cfgs_regfile #(.NREG(NREG), .STRAP_W(STRAP_W), .RST_IMAGE(RST_IMAGE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_byte(rd_byte), .strap_in(strap_in), .cfg_q(cfg_q)
  );
endmodule

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int Q = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic [3:0] strap = 4'hA;
  logic sda_oe;
  logic [47:0] cfg_q;
  logic sda_line;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [6];

  assign sda_line = host_sda & ~sda_oe;

  always #4 clk = ~clk;

  cfg_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap_in(strap), .cfg_q(cfg_q)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq();
    scl = 1'b1; wq();
    host_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq();
    scl = 1'b1; wq();
    host_sda = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; wq();
    scl = 1'b1; wq(2);
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_sda = 1'b1; wq();
    scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      b[i] = sda_line;
      wq();
      scl = 1'b0;
    end
    host_sda = ack ? 1'b0 : 1'b1; wq();
    scl = 1'b1; wq(2);
    scl = 1'b0; wq();
    host_sda = 1'b1;
  endtask

  function automatic logic [47:0] image();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[8*i +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic t_reset();
    check(cfg_q == 48'h0F_FF_FF_FF_FF_00, "R7 reset image", cfg_q, 48'h0F_FF_FF_FF_FF_00);
    check(sda_oe == 1'b0, "R7 sda released", sda_oe, 0);
  endtask

  task automatic t_full_write();
    logic a;
    logic [7:0] d [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hA6};
    bus_start();
    send_byte(8'hD2, a); check(a, "R1 write address ack", a, 1);
    send_byte(8'h5C, a); check(a, "R2 command byte ack", a, 1);
    send_byte(8'h09, a); check(a, "R2 count byte ack", a, 1);
    for (int i = 0; i < 6; i++) begin
      send_byte(d[i], a);
      check(a, "R4 data byte ack", a, 1);
      exp_r[i] = (i == 5) ? (d[i] & 8'h0F) : d[i];
    end
    bus_stop();
    check(cfg_q == image(), "R2 ascending store", cfg_q, image());
    check(cfg_q[47:44] == 4'h0, "R8 strap bits not writable", cfg_q[47:44], 0);
  endtask

  task automatic t_read(input int extra);
    logic a;
    logic [7:0] b, e;
    bus_start();
    send_byte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    read_byte(1'b1, b); check(b == 8'd6, "R5 byte count", b, 6);
    for (int i = 0; i < 6; i++) begin
      e = (i == 5) ? {4'hA, exp_r[5][3:0]} : exp_r[i];
      read_byte((i < 5) || (extra > 0), b);
      check(b == e, (i == 5) ? "R8 strap readback" : "R5 register readback", b, e);
    end
    for (int i = 0; i < extra; i++) begin
      read_byte(i < extra - 1, b);
      check(b == 8'hFF, "R5 past-end fill", b, 8'hFF);
    end
    wq();
    check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_partial();
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'hC0, a); exp_r[0] = 8'hC0;
    send_byte(8'hC1, a); exp_r[1] = 8'hC1;
    bus_stop();
    check(cfg_q == image(), "R3 partial write", cfg_q, image());
  endtask

  task automatic t_overflow();
    logic a;
    int nacks = 0;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    for (int i = 0; i < 8; i++) begin
      send_byte(8'h70 + 8'(i), a);
      if (!a) nacks++;
      if (i < 6) exp_r[i] = (i == 5) ? ((8'h70 + 8'(i)) & 8'h0F) : (8'h70 + 8'(i));
    end
    bus_stop();
    check(nacks == 0, "R4 overflow bytes acked", nacks, 0);
    check(cfg_q == image(), "R4 overflow ignored", cfg_q, image());
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hA0, a); check(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h3C, a); check(!a, "R1 stays idle", a, 0);
    bus_stop();
    check(cfg_q == image(), "R1 no change", cfg_q, image());
  endtask

  task automatic t_mid_abort();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check(cfg_q == image(), "R9 stop mid-byte", cfg_q, image());
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hD3, a); check(a, "R9 restart address ack", a, 1);
    read_byte(1'b0, b); check(b == 8'd6, "R9 restart read count", b, 6);
    bus_stop();
    check(cfg_q == image(), "R9 start mid-byte", cfg_q, image());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_r = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h0F};
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 strap = 4'h5;
    wq();
    t_reset();
    t_full_write();
    t_read(2);
    t_partial();
    t_overflow();
    t_read(0);
    t_wrong_addr();
    t_mid_abort();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule